// File: doc/BRIEF.md
# Merging Miss Status Holding Table

This block keeps track of cache-line misses that have been sent to the next memory level and have not yet come back. Each live slot is keyed by a block address. It holds a short in-order list of small request tags that all wait on that line, plus one flag that records whether any of those requests was atomic. A requester first looks up an address on the probe pins. It then offers the request on the add stream, which either opens a new slot or appends the tag to the slot that already waits on the same line.

When the line returns, the owner pulses the fill pins with the block address. That slot joins a response queue in the order the fills arrive, and the slot's atomic flag is returned in the same cycle. The drain stream then hands out the waiting tags one per accepted transfer. It takes them from the slot at the head of the response queue, oldest tag first. A slot is released, and its address stops matching, once its last tag has been accepted.

Back-pressure rules: on the add stream, `add_ready` depends only on `add_addr` and on table state, so a source may hold `add_valid` high and wait. An add transfer happens in a cycle where both `add_valid` and `add_ready` are high. On the drain stream, `drn_valid` never depends on `drn_ready`, and while `drn_valid` is high and `drn_ready` is low, the tag, address and flag on the drain pins hold their values. Fill is a plain strobe with no handshake.

Top module: `mshr_merge_table`

## Requirements
- R1: `probe_hit` is high exactly when a live slot holds `probe_addr`. `probe_full` is high when that slot already holds MERGE tags, or, for an address with no live slot, when all ENTRIES slots are live.
- R2: `add_ready` is low when `add_addr` matches a slot holding MERGE tags, and low when `add_addr` is new and all ENTRIES slots are live.
- R3: An accepted add to a new address opens a slot. An accepted add to a live, not yet returned address appends its tag to that slot and opens no new slot.
- R4: A slot's atomic flag is set if any tag added to it had `add_atomic` high. The flag is shown on `fill_atomic` (combinationally, for the slot matching `fill_addr`) and on `drn_atomic`.
- R5: A fill strobe on a live, not yet returned address places that slot in the response queue behind earlier fills. `drn_valid` is high exactly when the response queue is non-empty.
- R6: The drain pins show the oldest remaining tag of the slot at the head of the response queue, with that slot's address. Each accepted drain transfer moves to the next tag. The pins hold steady while `drn_valid` is high and `drn_ready` is low.
- R7: After the last tag of a slot is drained, the slot is freed: its address no longer probes as a hit, and its capacity can be used again.
- R8: A fill strobe whose address has no live slot, or whose slot has already returned, sets the sticky `err` output and changes no slot and no queue entry.
- R9: `add_ready` is low for an address whose slot has already returned.
- R10: After reset no slot is live, `probe_hit` and `drn_valid` are low, and `err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_addr | input | AW | Block address to look up |
| probe_hit | output | 1 | A live slot holds probe_addr |
| probe_full | output | 1 | An add for probe_addr would be refused for lack of room |
| add_valid | input | 1 | Add stream: request offered |
| add_ready | output | 1 | Add stream: request can be taken |
| add_addr | input | AW | Add stream: block address |
| add_id | input | IDW | Add stream: request tag |
| add_atomic | input | 1 | Add stream: request is atomic |
| fill_valid | input | 1 | Fill strobe: line for fill_addr has returned |
| fill_addr | input | AW | Fill strobe: block address |
| fill_atomic | output | 1 | Atomic flag of the slot matching fill_addr |
| drn_valid | output | 1 | Drain stream: a tag is available |
| drn_ready | input | 1 | Drain stream: consumer takes the tag |
| drn_addr | output | AW | Drain stream: block address of the tag |
| drn_id | output | IDW | Drain stream: request tag |
| drn_atomic | output | 1 | Drain stream: atomic flag of the slot |
| err | output | 1 | Sticky: a fill named an absent or already returned slot |

## Verification
The bench fills a small table with a different merge depth in every slot. It returns the lines in the reverse of their add order, so a design that drained in slot-index order or in add order would hand out tags under the wrong address. It presses on both refusal cases of the add stream and on a merge into a returned slot. A design that counted merges off by one, or kept merging after the fill, would show `add_ready` high where it must be low. It stalls the drain mid-slot, checks that the freed slots stop matching and are usable again, and sends a fill for an unknown line. A design with a leaky release or a silent error path would keep a stale hit or leave `err` low.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

  // Largest slot count the index helpers below accept.
  localparam int unsigned MAX_SLOTS = 64;

  // Position of the lowest set bit; 0 when no bit is set.
  function automatic int unsigned lowest_set(input logic [MAX_SLOTS-1:0] v);
    int unsigned r;
    r = 0;
    for (int i = MAX_SLOTS - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Number of set bits.
  function automatic int unsigned ones(input logic [MAX_SLOTS-1:0] v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < MAX_SLOTS; i++) begin
      r += v[i];
    end
    return r;
  endfunction

endpackage

// File: rtl/mshr_slot.sv
module mshr_slot #(
  parameter int unsigned AW    = 32,
  parameter int unsigned IDW   = 8,
  parameter int unsigned MERGE = 4,
  localparam int unsigned CW   = $clog2(MERGE + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_i,
  input  logic           merge_i,
  input  logic           mark_i,
  input  logic           pop_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [IDW-1:0] id_i,
  input  logic           atomic_i,
  output logic           valid_o,
  output logic [AW-1:0]  addr_o,
  output logic           atomic_o,
  output logic           marked_o,
  output logic [CW-1:0]  cnt_o,
  output logic [IDW-1:0] head_id_o,
  output logic           last_o
);

  logic           valid_q;
  logic [AW-1:0]  addr_q;
  logic           atomic_q;
  logic           marked_q;
  logic [CW-1:0]  cnt_q;
  logic [IDW-1:0] ids_q [MERGE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      addr_q   <= '0;
      atomic_q <= 1'b0;
      marked_q <= 1'b0;
      cnt_q    <= '0;
      for (int k = 0; k < MERGE; k++) ids_q[k] <= '0;
    end else if (alloc_i) begin
      valid_q  <= 1'b1;
      addr_q   <= addr_i;
      atomic_q <= atomic_i;
      marked_q <= 1'b0;
      cnt_q    <= CW'(1);
      ids_q[0] <= id_i;
    end else begin
      if (merge_i) begin
        for (int k = 0; k < MERGE; k++) begin
          if (CW'(k) == cnt_q) ids_q[k] <= id_i;
        end
        cnt_q <= cnt_q + CW'(1);
        if (atomic_i) atomic_q <= 1'b1;
      end
      if (mark_i) marked_q <= 1'b1;
      if (pop_i) begin
        for (int k = 0; k < MERGE - 1; k++) ids_q[k] <= ids_q[k+1];
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          valid_q  <= 1'b0;
          marked_q <= 1'b0;
          atomic_q <= 1'b0;
        end
      end
    end
  end

  assign valid_o   = valid_q;
  assign addr_o    = addr_q;
  assign atomic_o  = atomic_q;
  assign marked_o  = marked_q;
  assign cnt_o     = cnt_q;
  assign head_id_o = ids_q[0];
  assign last_o    = (cnt_q == CW'(1));

  AST_SLOT_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (cnt_q >= CW'(1) && cnt_q <= CW'(MERGE))); // R3
  AST_SLOT_POP_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (valid_q && marked_q)); // R6
  AST_SLOT_NO_MERGE_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
    merge_i |-> (valid_q && !marked_q && !mark_i)); // R9
  AST_SLOT_ATOMIC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && atomic_q && !(pop_i && last_o)) |=> atomic_q); // R4

endmodule

// File: rtl/mshr_rdy_fifo.sv
module mshr_rdy_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 3,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned NW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [NW-1:0] num_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      num_q <= '0;
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= push_data_i;
        wr_q        <= step(wr_q);
      end
      if (pop_i) rd_q <= step(rd_q);
      if (push_i && !pop_i) num_q <= num_q + NW'(1);
      else if (pop_i && !push_i) num_q <= num_q - NW'(1);
    end
  end

  assign head_o  = mem_q[rd_q];
  assign empty_o = (num_q == '0);
  assign full_o  = (num_q == NW'(DEPTH));

  AST_RQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o); // R5
  AST_RQ_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o); // R6

endmodule

// File: rtl/mshr_merge_table.sv
module mshr_merge_table #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned MERGE   = 4,
  parameter int unsigned AW      = 32,
  parameter int unsigned IDW     = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  probe_addr,
  output logic           probe_hit,
  output logic           probe_full,
  input  logic           add_valid,
  output logic           add_ready,
  input  logic [AW-1:0]  add_addr,
  input  logic [IDW-1:0] add_id,
  input  logic           add_atomic,
  input  logic           fill_valid,
  input  logic [AW-1:0]  fill_addr,
  output logic           fill_atomic,
  output logic           drn_valid,
  input  logic           drn_ready,
  output logic [AW-1:0]  drn_addr,
  output logic [IDW-1:0] drn_id,
  output logic           drn_atomic,
  output logic           err
);
  import mshr_pkg::*;

  localparam int unsigned IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int unsigned CW = $clog2(MERGE + 1);
  localparam int unsigned LW = $clog2(ENTRIES + 1);

  // Slot state seen from the top
  logic [ENTRIES-1:0] s_valid, s_atomic, s_marked, s_last;
  logic [AW-1:0]      s_addr    [ENTRIES];
  logic [CW-1:0]      s_cnt     [ENTRIES];
  logic [IDW-1:0]     s_head_id [ENTRIES];

  // Slot controls
  logic [ENTRIES-1:0] do_alloc, do_merge, do_mark, do_pop;

  // Address match vectors
  logic [ENTRIES-1:0] pm, am, fm;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    assign pm[e] = s_valid[e] && (s_addr[e] == probe_addr);
    assign am[e] = s_valid[e] && (s_addr[e] == add_addr);
    assign fm[e] = s_valid[e] && (s_addr[e] == fill_addr);

    mshr_slot #(.AW(AW), .IDW(IDW), .MERGE(MERGE)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_i   (do_alloc[e]),
      .merge_i   (do_merge[e]),
      .mark_i    (do_mark[e]),
      .pop_i     (do_pop[e]),
      .addr_i    (add_addr),
      .id_i      (add_id),
      .atomic_i  (add_atomic),
      .valid_o   (s_valid[e]),
      .addr_o    (s_addr[e]),
      .atomic_o  (s_atomic[e]),
      .marked_o  (s_marked[e]),
      .cnt_o     (s_cnt[e]),
      .head_id_o (s_head_id[e]),
      .last_o    (s_last[e])
    );
  end

  // Lookups of the matched slot for each port
  logic [CW-1:0] p_cnt, a_cnt;
  logic          a_marked, f_marked, f_atomic;
  logic [IW-1:0] f_idx;

  always_comb begin
    p_cnt    = '0;
    a_cnt    = '0;
    a_marked = 1'b0;
    f_marked = 1'b0;
    f_atomic = 1'b0;
    f_idx    = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (pm[e]) p_cnt = p_cnt | s_cnt[e];
      if (am[e]) begin
        a_cnt    = a_cnt | s_cnt[e];
        a_marked = a_marked | s_marked[e];
      end
      if (fm[e]) begin
        f_marked = f_marked | s_marked[e];
        f_atomic = f_atomic | s_atomic[e];
        f_idx    = f_idx | IW'(e);
      end
    end
  end

  // Occupancy and free slot choice
  logic [LW-1:0] live;
  logic [IW-1:0] free_idx;

  always_comb begin
    live     = LW'(ones(MAX_SLOTS'(s_valid)));
    free_idx = IW'(lowest_set(MAX_SLOTS'(~s_valid)));
  end

  // Probe port
  assign probe_hit  = |pm;
  assign probe_full = probe_hit ? (p_cnt >= CW'(MERGE)) : (live >= LW'(ENTRIES));

  // Add stream
  logic add_hit, add_full, add_fire;
  assign add_hit   = |am;
  assign add_full  = add_hit ? (a_cnt >= CW'(MERGE)) : (live >= LW'(ENTRIES));
  assign add_ready = !add_full && !(add_hit && a_marked);
  assign add_fire  = add_valid && add_ready;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_add
    assign do_alloc[e] = add_fire && !add_hit && (free_idx == IW'(e));
    assign do_merge[e] = add_fire && am[e];
  end

  // Fill strobe
  logic fill_ok;
  assign fill_ok     = fill_valid && (|fm) && !f_marked;
  assign fill_atomic = f_atomic;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_mark
    assign do_mark[e] = fill_ok && fm[e];
  end

  // Response queue and drain stream
  logic [IW-1:0] head_idx;
  logic          rq_empty, rq_full, drn_fire, rq_pop;

  mshr_rdy_fifo #(.DEPTH(ENTRIES), .W(IW)) u_rq (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (fill_ok),
    .push_data_i (f_idx),
    .pop_i       (rq_pop),
    .head_o      (head_idx),
    .empty_o     (rq_empty),
    .full_o      (rq_full)
  );

  assign drn_valid  = !rq_empty;
  assign drn_id     = s_head_id[head_idx];
  assign drn_addr   = s_addr[head_idx];
  assign drn_atomic = s_atomic[head_idx];
  assign drn_fire   = drn_valid && drn_ready;
  assign rq_pop     = drn_fire && s_last[head_idx];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_pop
    assign do_pop[e] = drn_fire && (head_idx == IW'(e));
  end

  // Sticky error
  logic err_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                      err_q <= 1'b0;
    else if (fill_valid && !fill_ok) err_q <= 1'b1;
  end
  assign err = err_q;

  AST_ADD_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(am)); // R3
  AST_ADD_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (add_fire && !add_hit) |-> (live < LW'(ENTRIES))); // R2
  AST_DRN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (drn_valid && !drn_ready) |=> (drn_valid && $stable(drn_id) && $stable(drn_addr))); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R8
  AST_DRN_FROM_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
    drn_valid |-> (s_valid[head_idx] && s_marked[head_idx])); // R5

endmodule

// File: tb/mshr_merge_table_tb.sv
module mshr_merge_table_tb_top;

  localparam int unsigned E   = 4;
  localparam int unsigned M   = 3;
  localparam int unsigned AW  = 8;
  localparam int unsigned IDW = 6;
  localparam time         TCK = 20ns;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [AW-1:0]  probe_addr = '0;
  logic           probe_hit, probe_full;
  logic           add_valid = 1'b0;
  logic           add_ready;
  logic [AW-1:0]  add_addr = '0;
  logic [IDW-1:0] add_id = '0;
  logic           add_atomic = 1'b0;
  logic           fill_valid = 1'b0;
  logic [AW-1:0]  fill_addr = '0;
  logic           fill_atomic;
  logic           drn_valid;
  logic           drn_ready = 1'b0;
  logic [AW-1:0]  drn_addr;
  logic [IDW-1:0] drn_id;
  logic           drn_atomic;
  logic           err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(TCK/2) clk = ~clk;

  mshr_merge_table #(.ENTRIES(E), .MERGE(M), .AW(AW), .IDW(IDW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .probe_addr(probe_addr), .probe_hit(probe_hit), .probe_full(probe_full),
    .add_valid(add_valid), .add_ready(add_ready), .add_addr(add_addr),
    .add_id(add_id), .add_atomic(add_atomic),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_atomic(fill_atomic),
    .drn_valid(drn_valid), .drn_ready(drn_ready), .drn_addr(drn_addr),
    .drn_id(drn_id), .drn_atomic(drn_atomic), .err(err)
  );

  // Stimulus model
  function automatic logic [AW-1:0] addr_of(int e);
    return AW'(8'h40 + e * 5);
  endfunction
  function automatic int depth_of(int e);
    return (e % M) + 1;
  endfunction
  function automatic logic [IDW-1:0] id_of(int e, int j);
    return IDW'(e * 8 + j);
  endfunction
  function automatic bit atom_of(int e, int j);
    return (e == 1 && j == 1) || (e == 2 && j == 0);
  endfunction
  function automatic bit slot_atomic(int e);
    bit a;
    a = 1'b0;
    for (int j = 0; j < depth_of(e); j++) a |= atom_of(e, j);
    return a;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_add(input logic [AW-1:0] a, input logic [IDW-1:0] id, input bit at);
    @(negedge clk);
    add_valid = 1'b1; add_addr = a; add_id = id; add_atomic = at;
    #1;
    chk(add_ready == 1'b1, "R3 add accepted", add_ready, 1);
    @(posedge clk); #1;
    add_valid = 1'b0; add_atomic = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [IDW-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // Reset state
    probe_addr = addr_of(0); #1;
    chk(probe_hit == 1'b0, "R10 no hit after reset", probe_hit, 0);
    chk(drn_valid == 1'b0, "R10 drain idle after reset", drn_valid, 0);
    chk(err == 1'b0, "R10 err clear after reset", err, 0);

    // Build slots with a different merge depth each
    for (int e = 0; e < E; e++) begin
      for (int j = 0; j < depth_of(e); j++) begin
        do_add(addr_of(e), id_of(e, j), atom_of(e, j));
        probe_addr = addr_of(e); #1;
        chk(probe_hit == 1'b1, "R1 probe hit after add", probe_hit, 1);
        chk(probe_full == (j + 1 == M), "R1 probe_full for merge depth",
            probe_full, (j + 1 == M));
      end
    end

    @(negedge clk); #1;
    add_addr = 8'h99; probe_addr = 8'h99; #1;
    chk(add_ready == 1'b0, "R2 new address refused when table full", add_ready, 0);
    chk(probe_full == 1'b1, "R1 probe_full for new address", probe_full, 1);
    chk(probe_hit == 1'b0, "R1 absent address misses", probe_hit, 0);
    add_addr = addr_of(2); #1;
    chk(add_ready == 1'b0, "R2 merge refused at MERGE tags", add_ready, 0);
    add_addr = addr_of(1); #1;
    chk(add_ready == 1'b1, "R3 merge still open below MERGE", add_ready, 1);
    chk(drn_valid == 1'b0, "R5 drain idle before any fill", drn_valid, 0);

    // Return lines in reverse order
    for (int e = E - 1; e >= 0; e--) begin
      @(negedge clk);
      fill_valid = 1'b1; fill_addr = addr_of(e); #1;
      chk(fill_atomic == slot_atomic(e), "R4 fill_atomic", fill_atomic, slot_atomic(e));
      @(posedge clk); #1;
      fill_valid = 1'b0;
      chk(drn_valid == 1'b1, "R5 drain valid after fill", drn_valid, 1);
      add_addr = addr_of(e); #1;
      chk(add_ready == 1'b0, "R9 merge into returned slot refused", add_ready, 0);
    end
    chk(err == 1'b0, "R8 err clear after legal fills", err, 0);

    // Drain in fill order, tags in add order, with one stall
    for (int e = E - 1; e >= 0; e--) begin
      for (int j = 0; j < depth_of(e); j++) begin
        @(negedge clk);
        if (e == 2 && j == 1) begin
          drn_ready = 1'b0; #1;
          held = drn_id;
          @(negedge clk); #1;
          chk(drn_id == held, "R6 tag holds under stall", drn_id, held);
          chk(drn_valid == 1'b1, "R6 valid holds under stall", drn_valid, 1);
        end
        drn_ready = 1'b1; #1;
        chk(drn_valid == 1'b1, "R5 drain valid while queued", drn_valid, 1);
        chk(drn_id == id_of(e, j), "R6 drain tag order", drn_id, id_of(e, j));
        chk(drn_addr == addr_of(e), "R6 drain address", drn_addr, addr_of(e));
        chk(drn_atomic == slot_atomic(e), "R4 drn_atomic", drn_atomic, slot_atomic(e));
        @(posedge clk); #1;
        drn_ready = 1'b0;
      end
      probe_addr = addr_of(e); #1;
      chk(probe_hit == 1'b0, "R7 slot freed after last tag", probe_hit, 0);
    end

    @(negedge clk); #1;
    chk(drn_valid == 1'b0, "R5 drain idle when queue empty", drn_valid, 0);
    add_addr = 8'h99; #1;
    chk(add_ready == 1'b1, "R7 capacity regained", add_ready, 1);

    // Fill for an absent line
    fill_valid = 1'b1; fill_addr = 8'h77;
    @(posedge clk); #1;
    fill_valid = 1'b0;
    @(negedge clk); #1;
    chk(err == 1'b1, "R8 err set by unknown fill", err, 1);
    chk(drn_valid == 1'b0, "R8 unknown fill queues nothing", drn_valid, 0);
    probe_addr = 8'h77; #1;
    chk(probe_hit == 1'b0, "R8 unknown fill opens no slot", probe_hit, 0);

    // Fill twice on one slot: table left as after the first fill
    do_add(8'h20, 6'h15, 1'b0);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = 8'h20;
    @(posedge clk); #1;
    @(negedge clk);
    @(posedge clk); #1;
    fill_valid = 1'b0;
    @(negedge clk);
    drn_ready = 1'b1; #1;
    chk(drn_id == 6'h15, "R8 repeated fill keeps slot", drn_id, 6'h15);
    @(posedge clk); #1;
    drn_ready = 1'b0;
    @(negedge clk); #1;
    chk(drn_valid == 1'b0, "R8 repeated fill queues once", drn_valid, 0);
    chk(err == 1'b1, "R8 err stays set", err, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule